// File: doc/BRIEF.md
# I2C Controller Control and Status Registers

This block holds the software-visible control and status state of an I2C controller whose protocol engine reports progress as 8-bit state codes. The control register contains the enables, the serial interrupt flag and the start, stop and acknowledge requests. The read-only status register shows the most recent state code. Each new code sets the interrupt flag. When the interrupt enable bit is also set, an interrupt request goes out to the processor.

The protocol engine is an input port. It gives a state code with a strobe, flags a START or STOP condition seen at an illegal point in a frame (a bus error), and reports a STOP condition seen on the bus. Codes that arrive while software is still servicing the flag wait in a small ordered queue. The queue depth is a parameter. The block also carries out the bus-error recovery handshake and gives the engine a one-cycle pulse that sends it to not-addressed slave mode.

Control register bit map: bit 7 interrupt enable, bit 6 controller enable, bit 5 start request, bit 4 stop request, bit 3 serial interrupt flag, bit 2 assert-acknowledge, bits 1:0 plain read/write bits with no function.

Top module: `i2c_ctlstat_regs`

## Requirements
- R1: After reset the control readback is 00h, the status readback is F8h, and irq and nas_enter are low.
- R2: A CPU write stores every control bit, with one exception: bit 3 (the flag) can only be cleared by a write of 0, and a write of 1 to it leaves it unchanged. The new value is visible on the cycle after the write.
- R3: When the controller is enabled and the flag is clear, a code strobe sets the flag on the next clock edge. The code appears on the status readback one clock edge after that.
- R4: irq is high exactly when bit 7 and bit 3 of the control register are both set.
- R5: The status readback holds its code unchanged while the flag stays set, and for one cycle after software clears the flag. It then returns to F8h.
- R6: Codes that arrive while the flag is set queue in arrival order, up to PEND_DEPTH entries, and any further arrival is dropped. After each clear of the flag, the oldest queued code sets the flag again on the following edge.
- R7: A bus-error strobe posts code 00h. It takes priority over a code strobe in the same cycle.
- R8: A bus STOP report clears bit 4 on the next edge, even when a CPU write sets bit 4 in the same cycle.
- R9: A control value with bit 6 at 0 clears bits 4 and 3. While the controller is disabled, the status readback is F8h, the queue is flushed and strobes are ignored.
- R10: Software may write bit 4 = 1 and bit 3 = 0 while the flag is set and the current code is 00h. nas_enter then pulses for exactly one cycle, and bit 4 clears on the edge after, without any bus STOP report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Control register write strobe |
| cpu_wdata | input | 8 | Control register write data |
| ctl_rd | output | 8 | Control register readback |
| stat_rd | output | 8 | Status register readback |
| irq | output | 1 | Interrupt request |
| eng_code_vld | input | 1 | Engine state code strobe |
| eng_code | input | 8 | Engine state code |
| eng_bus_err | input | 1 | Misplaced START/STOP detected |
| eng_stop_seen | input | 1 | STOP condition detected on the bus |
| nas_enter | output | 1 | Pulse: engine enters not-addressed slave mode |

## Verification
The bench builds the block with PEND_DEPTH of 2, the idle code F8h and the error code 00h. With a depth of 2, three strobes in a row while the flag is set are enough to fill the queue and drop the third code. The bench then drains the queue one software clear at a time, so the order of replay is visible on the status port. The default codes let the bus-error strobe lead directly into the recovery write, and they make the idle value after a disable easy to tell apart from any code the engine posts.

// File: rtl/i2c_ctlstat_pkg.sv
package i2c_ctlstat_pkg;
   localparam int CTL_W  = 8;
   localparam int B_IE   = 7;
   localparam int B_EN   = 6;
   localparam int B_STA  = 5;
   localparam int B_STO  = 4;
   localparam int B_SI   = 3;
   localparam int B_AA   = 2;
   typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/i2c_code_queue.sv
module i2c_code_queue #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic         vld,
   output logic [W-1:0] dout
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("i2c_code_queue: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic         full_q;
      logic [W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            slot_q <= '0;
         end else if (flush) begin
            full_q <= 1'b0;
         end else begin
            if (push && (!full_q || pop)) begin
               full_q <= 1'b1;
               slot_q <= din;
            end else if (pop) begin
               full_q <= 1'b0;
            end
         end
      end
      assign vld  = full_q;
      assign dout = slot_q;
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      localparam int CNT_W = $clog2(DEPTH + 1);
      localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
      localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

      logic [W-1:0]     mem_q [DEPTH];
      logic [PTR_W-1:0] rd_q, wr_q;
      logic [CNT_W-1:0] cnt_q;
      logic             do_pop, do_push;

      assign do_pop  = pop && (cnt_q != '0);
      assign do_push = push && ((cnt_q != CAP) || do_pop);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
         end else if (flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem_q[wr_q] <= din;
      end

      assign vld  = (cnt_q != '0);
      assign dout = mem_q[rd_q];

      a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CAP);
      a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == CAP && push && !pop && !flush) |=> cnt_q == CAP);
   end
endmodule

// File: rtl/i2c_status_reg.sv
module i2c_status_reg #(
   parameter int          W         = 8,
   parameter logic [W-1:0] IDLE_CODE = 8'hF8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_q,
   input  logic         si_q,
   input  logic [W-1:0] code_hold,
   output logic [W-1:0] stat_q
);
   logic si_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         si_prev_q <= 1'b0;
         stat_q    <= IDLE_CODE;
      end else begin
         si_prev_q <= si_q;
         if (!en_q)                   stat_q <= IDLE_CODE;
         else if (si_q && !si_prev_q) stat_q <= code_hold;
         else if (!si_q && si_prev_q) stat_q <= IDLE_CODE;
      end
   end

   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (si_q && $past(si_q) && $past(si_q, 2) && en_q && $past(en_q)) |-> $stable(stat_q));
   a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> stat_q == IDLE_CODE);
endmodule

// File: rtl/i2c_ctlstat_regs.sv
module i2c_ctlstat_regs
   import i2c_ctlstat_pkg::*;
#(
   parameter int         PEND_DEPTH = 2,
   parameter logic [7:0] IDLE_CODE  = 8'hF8,
   parameter logic [7:0] BERR_CODE  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_wr,
   input  logic [7:0] cpu_wdata,
   output logic [7:0] ctl_rd,
   output logic [7:0] stat_rd,
   output logic       irq,
   input  logic       eng_code_vld,
   input  logic [7:0] eng_code,
   input  logic       eng_bus_err,
   input  logic       eng_stop_seen,
   output logic       nas_enter
);
   if (IDLE_CODE == BERR_CODE) begin : g_bad_codes
      $error("i2c_ctlstat_regs: idle and bus-error codes must differ");
   end

   ctl_t       ctl_q, ctl_nx;
   logic [7:0] hold_q;
   logic       nas_q, recov_d;
   logic       en_q, si_q, en_nx;
   logic       in_vld, src_vld, take;
   logic [7:0] in_code, src_code;
   logic       q_vld, q_push, q_pop;
   logic [7:0] q_dout;

   assign en_q = ctl_q[B_EN];
   assign si_q = ctl_q[B_SI];

   assign in_vld   = en_q && (eng_code_vld || eng_bus_err);
   assign in_code  = eng_bus_err ? BERR_CODE : eng_code;
   assign src_vld  = q_vld || in_vld;
   assign src_code = q_vld ? q_dout : in_code;
   assign take     = src_vld && en_q && !si_q;
   assign q_pop    = take && q_vld;
   assign q_push   = in_vld && !(take && !q_vld);

   i2c_code_queue #(.W(8), .DEPTH(PEND_DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!en_q),
      .push  (q_push),
      .din   (in_code),
      .pop   (q_pop),
      .vld   (q_vld),
      .dout  (q_dout)
   );

   assign en_nx   = cpu_wr ? cpu_wdata[B_EN] : en_q;
   assign recov_d = cpu_wr && cpu_wdata[B_STO] && !cpu_wdata[B_SI]
                    && si_q && en_q && (hold_q == BERR_CODE);

   always_comb begin
      ctl_nx = ctl_q;
      if (cpu_wr) begin
         ctl_nx       = cpu_wdata;
         ctl_nx[B_SI] = si_q && cpu_wdata[B_SI];
      end
      if (take) ctl_nx[B_SI] = 1'b1;
      if (eng_stop_seen || nas_q || !en_nx) ctl_nx[B_STO] = 1'b0;
      if (!en_nx) ctl_nx[B_SI] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         hold_q <= IDLE_CODE;
         nas_q  <= 1'b0;
      end else begin
         ctl_q <= ctl_nx;
         nas_q <= recov_d;
         if (take) hold_q <= src_code;
      end
   end

   i2c_status_reg #(.W(8), .IDLE_CODE(IDLE_CODE)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_q      (en_q),
      .si_q      (si_q),
      .code_hold (hold_q),
      .stat_q    (stat_rd)
   );

   assign ctl_rd    = ctl_q;
   assign irq       = ctl_q[B_IE] && ctl_q[B_SI];
   assign nas_enter = nas_q;

   a_r2_si_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(si_q) |-> $past(cpu_wr));
   a_r3_si_from_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(si_q) |-> $past(src_vld));
   a_r8_stop_seen_clears: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stop_seen |=> !ctl_q[B_STO]);
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      nas_q |=> (!nas_q && !ctl_q[B_STO]));
endmodule

// File: tb/test_i2c_ctlstat_regs.sv
module test_i2c_ctlstat_regs;
   localparam int DEPTH = 2;
   localparam logic [7:0] IDLE = 8'hF8;
   localparam logic [7:0] BERR = 8'h00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic       d_wr = 0, d_vld = 0, d_err = 0, d_stp = 0;
   logic [7:0] d_wd = 0, d_code = 0;
   logic [7:0] ctl_rd, stat_rd;
   logic       irq, nas_enter;

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit done = 0;

   always #10 clk = ~clk;

   i2c_ctlstat_regs #(.PEND_DEPTH(DEPTH), .IDLE_CODE(IDLE), .BERR_CODE(BERR)) i_i2c_ctlstat_regs (
      .clk(clk), .rst_n(rst_n), .cpu_wr(d_wr), .cpu_wdata(d_wd),
      .ctl_rd(ctl_rd), .stat_rd(stat_rd), .irq(irq),
      .eng_code_vld(d_vld), .eng_code(d_code), .eng_bus_err(d_err),
      .eng_stop_seen(d_stp), .nas_enter(nas_enter));

   // reference model state
   logic       m_ie = 0, m_en = 0, m_sta = 0, m_sto = 0, m_si = 0, m_aa = 0;
   logic [1:0] m_sp = 0;
   logic [7:0] m_stat = IDLE, m_hold = IDLE;
   logic       m_sip = 0, m_nas = 0;
   logic [7:0] mq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_ie, m_en, m_sta, m_sto, m_si, m_aa} = '0;
         m_sp = 0; m_stat = IDLE; m_hold = IDLE; m_sip = 0; m_nas = 0;
         mq.delete();
      end else begin
         bit in_v, src_v, tk, en_nx, nas_n, si_n, sto_n, q_empty;
         logic [7:0] in_c, src_c;
         in_v    = m_en && (d_vld || d_err);
         in_c    = d_err ? BERR : d_code;
         q_empty = (mq.size() == 0);
         src_v   = !q_empty || in_v;
         src_c   = q_empty ? in_c : mq[0];
         tk      = src_v && m_en && !m_si;
         en_nx   = d_wr ? d_wd[6] : m_en;
         nas_n   = d_wr && d_wd[4] && !d_wd[3] && m_si && m_en && (m_hold == BERR);
         // status pipeline
         if (!m_en)               m_stat = IDLE;
         else if (m_si && !m_sip) m_stat = m_hold;
         else if (!m_si && m_sip) m_stat = IDLE;
         m_sip = m_si;
         // queue
         if (!m_en) mq.delete();
         else begin
            if (tk && !q_empty) void'(mq.pop_front());
            if (in_v && !(tk && q_empty) && mq.size() < DEPTH) mq.push_back(in_c);
         end
         if (tk) m_hold = src_c;
         // control bits
         if (tk) si_n = 1;
         else if (d_wr && !d_wd[3]) si_n = 0;
         else si_n = m_si;
         if (!en_nx) si_n = 0;
         sto_n = d_wr ? d_wd[4] : m_sto;
         if (d_stp || m_nas || !en_nx) sto_n = 0;
         if (d_wr) begin
            m_ie = d_wd[7]; m_sta = d_wd[5]; m_aa = d_wd[2]; m_sp = d_wd[1:0];
         end
         m_en = en_nx; m_si = si_n; m_sto = sto_n; m_nas = nas_n;
      end
   end

   task automatic compare();
      logic [7:0] e_ctl;
      e_ctl = {m_ie, m_en, m_sta, m_sto, m_si, m_aa, m_sp};
      n_cmp++;
      if (ctl_rd !== e_ctl || stat_rd !== m_stat || irq !== (m_ie && m_si) || nas_enter !== m_nas) begin
         n_bad++;
         $display("FAIL %s t=%0t ctl act %h exp %h | stat act %h exp %h | irq act %b exp %b | nas act %b exp %b",
                  cur_req, $time, ctl_rd, e_ctl, stat_rd, m_stat, irq, m_ie && m_si, nas_enter, m_nas);
      end
   endtask

   task automatic cyc(input logic w, input logic [7:0] wd, input logic v,
                      input logic [7:0] c, input logic e, input logic s);
      @(negedge clk);
      compare();
      d_wr = w; d_wd = wd; d_vld = v; d_code = c; d_err = e; d_stp = s;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 8'h00, 0, 0);
   endtask

   task automatic wr(input logic [7:0] v);
      cyc(1, v, 0, 8'h00, 0, 0);
   endtask

   task automatic code(input logic [7:0] c);
      cyc(0, 8'h00, 1, c, 0, 0);
   endtask

   initial begin
      cur_req = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(2);
      cur_req = "R2";               // enable, ie, ack, spare bits, si write of 1 ignored
      wr(8'hC7); idle(1);
      wr(8'hCF); idle(1);
      wr(8'hE4); idle(1);
      cur_req = "R3";
      code(8'h08); idle(3);
      cur_req = "R4";
      wr(8'hCC); idle(1);           // si stays, irq asserted
      cur_req = "R5";
      wr(8'hC4); idle(3);
      cur_req = "R6";
      code(8'h18);
      code(8'h28); code(8'h30); code(8'h40); idle(2);
      wr(8'hC4); idle(3);
      wr(8'hC4); idle(3);
      wr(8'hC4); idle(3);
      cur_req = "R7";
      cyc(0, 8'h00, 1, 8'h50, 1, 0); idle(3);
      cur_req = "R10";
      wr(8'hD4); idle(4);
      cur_req = "R8";
      wr(8'hD4); idle(2);
      cyc(0, 8'h00, 0, 8'h00, 0, 1); idle(2);
      cyc(1, 8'hD4, 0, 8'h00, 0, 1); idle(2);
      cur_req = "R9";
      wr(8'hD4); code(8'h58); idle(1);
      code(8'h60); code(8'h68); idle(1);
      wr(8'h14); idle(2);
      code(8'h70); cyc(0, 8'h00, 0, 8'h00, 1, 0); idle(2);
      wr(8'hC4); idle(3);
      cur_req = "R4";
      wr(8'h44); code(8'h78); idle(3);
      wr(8'h44); idle(3);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule